// File: doc/BRIEF.md
# Interrupt Redistributor Control Register

This block is the per-processor control and status word of an interrupt redistributor. Software reaches it through a single-word memory-mapped port. Each access carries a secure or non-secure attribute. The word holds three per-group "keep this processor out of one-of-N selection" bits and an enable for message-signalled interrupts. It also reports two pending flags and two read-only capability flags. Straps that are fixed while the chip runs decide which fields exist and who may touch them.

Some writes take time to reach the rest of the system: a change to an exclude bit, or turning the enable off. Each such write raises a one-cycle propagation request, and the write-pending flag stays high until the matching acknowledge returns. Turning the enable on raises a start pulse for the pending-table load. The flag then stays high until the loader reports completion. While the enable is off, doorbell requests and translation requests for this processor are discarded. The block also computes, for each interrupt group, whether this processor may be chosen by one-of-N distribution. When an exclude bit changes for the group of an interrupt already forwarded here, the block pulses a reselection request.

Top module: `rdist_ctl_reg`

## Requirements
- R1: After reset the three exclude bits, the enable, the write-pending flag, `prop_req`, `load_start`, `resel_req` and `proto_err` are all 0.
- R2: Read layout: bit 31 mirrors `upstream_busy`; bits 26/25/24 are the exclude bits for secure group 1, non-secure group 1 and group 0; bit 3 is write-pending; bit 2 is `cap_inval`; bit 1 is `cap_clearable`; bit 0 is the enable. Every other bit reads 0.
- R3: With `cap_excl` = 0 the three exclude bits read 0 and writes to them have no effect.
- R4: With `cap_one_sec` = 0, non-secure accesses cannot write bits 26 and 24 and read them as 0, while bit 25 stays accessible. With `cap_one_sec` = 1, bit 26 always reads 0 and ignores writes, and bit 24 is accessible to both kinds of access.
- R5: A write that changes any exclude bit, or clears the enable from 1 to 0, pulses `prop_req` for one cycle in the cycle after the write. Write-pending stays 1 until as many `prop_ack` pulses have arrived as requests were issued. A write that changes nothing propagating raises no request.
- R6: A write taking the enable from 0 to 1 pulses `load_start` for one cycle in the cycle after the write. Write-pending stays 1 until `load_done`.
- R7: With `cap_msi` = 0 the enable reads 0, ignores writes and never starts a load.
- R8: While the enable is 0, `doorbell_out` and `xlate_accept` are 0 whatever their inputs. While it is 1 they follow `doorbell_in` and `xlate_in`.
- R9: `elig[g]` (index 0 = group 0, 1 = non-secure group 1, 2 = secure group 1) is 1 only when `grp_en[g]` is 1 and exclude bit g is 0, and the processor is awake or `wake_flag` is 1. With `pe_asleep` = 1 and `wake_flag` = 0 all of `elig` is 0.
- R10: When `fwd_valid` is 1 and a write changes the exclude bit of group `fwd_grp` (same encoding as R9; 3 = none), `resel_req` pulses for one cycle in the cycle after the write. A change in another group raises no pulse.
- R11: A 0-to-1 enable write while an earlier enable clear is still unacknowledged is ignored and sets `proto_err`. A clear attempt while `cap_clearable` = 0 also sets it. `proto_err` then stays 1 until reset.
- R12: With `cap_clearable` = 0, an enable that is set stays 1 when 0 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_excl | input | 1 | Strap: exclude bits implemented |
| cap_one_sec | input | 1 | Strap: only one security state |
| cap_msi | input | 1 | Strap: physical message interrupts supported |
| cap_inval | input | 1 | Strap: invalidate registers present (read at bit 2) |
| cap_clearable | input | 1 | Strap: enable may be cleared (read at bit 1) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access attribute: 1 secure, 0 non-secure |
| bus_rdata | output | 32 | Read data for the current attribute |
| upstream_busy | input | 1 | Upstream writes not yet delivered |
| prop_req | output | 1 | One-cycle request to propagate a change |
| prop_ack | input | 1 | One propagation finished |
| load_start | output | 1 | One-cycle start of pending-table load |
| load_done | input | 1 | Pending-table load finished |
| msi_en | output | 1 | Message interrupts enabled |
| doorbell_in | input | 1 | Doorbell request from a virtual interrupt write |
| doorbell_out | output | 1 | Doorbell request passed on |
| xlate_in | input | 1 | Translation request or command for this processor |
| xlate_accept | output | 1 | Translation request accepted |
| pe_asleep | input | 1 | Processor asleep |
| wake_flag | input | 1 | Sleeping processors may still be chosen |
| grp_en | input | 3 | Per-group interrupt enable of the processor |
| elig | output | 3 | Per-group one-of-N eligibility |
| fwd_valid | input | 1 | An interrupt is forwarded to this processor |
| fwd_grp | input | 2 | Group of the forwarded interrupt |
| resel_req | output | 1 | One-cycle request to pick another target |
| proto_err | output | 1 | Sticky illegal enable sequencing flag |

## Verification
Read data, `msi_en`, the discard gates and `elig` depend combinationally on the stored state. So they are due in the same cycle as the clock edge that takes the write, and the bench samples them at the falling edge right after it. `prop_req`, `load_start` and `resel_req` are registered pulses that are high only in the cycle after the write edge. The bench checks them at that same falling edge and checks again one cycle later that the pulse has ended. The write-pending flag drops in the cycle after the last acknowledge or done strobe, so each acknowledge task ends on a falling edge and the flag is read there.

// File: rtl/rdist_ctl_pkg.sv
// Shared constants and types for the redistributor control register.
// Bit positions are fixed because software decodes the word.
package rdist_ctl_pkg;
    localparam int REG_W      = 32;
    localparam int N_GRP      = 3;
    localparam int BIT_UPEND  = 31;
    localparam int BIT_EXCL0  = 24;   // exclude bits occupy 24 + group index
    localparam int BIT_WPEND  = 3;
    localparam int BIT_INVAL  = 2;
    localparam int BIT_CLRCAP = 1;
    localparam int BIT_EN     = 0;

    // group index used for exclude bits, eligibility and forwarded group
    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_G1NS = 2'd1,
        GRP_G1S  = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    typedef struct packed {
        logic excl;
        logic one_sec;
        logic msi;
        logic inval;
        logic clrcap;
    } caps_t;
endpackage

// File: rtl/rdist_access_gate.sv
// Access gate: decides per access which exclude bits are visible and
// writable, and assembles the read word.
// Assumes straps are static while out of reset.
module rdist_access_gate
    import rdist_ctl_pkg::*;
(
    input  caps_t              caps,
    input  logic               secure,
    input  logic [N_GRP-1:0]   excl_q,
    input  logic               en_q,
    input  logic               wpend,
    input  logic               upstream_busy,
    output logic [N_GRP-1:0]   wmask,
    output logic [REG_W-1:0]   rdata
);
    // per-group access rule
    always_comb begin
        wmask           = '0;
        wmask[GRP_G0]   = caps.excl & (caps.one_sec | secure);
        wmask[GRP_G1NS] = caps.excl;
        wmask[GRP_G1S]  = caps.excl & ~caps.one_sec & secure;
    end

    // read word assembly
    always_comb begin
        rdata             = '0;
        rdata[BIT_UPEND]  = upstream_busy;
        for (int g = 0; g < N_GRP; g++) begin
            rdata[BIT_EXCL0 + g] = excl_q[g] & wmask[g];
        end
        rdata[BIT_WPEND]  = wpend;
        rdata[BIT_INVAL]  = caps.inval;
        rdata[BIT_CLRCAP] = caps.clrcap;
        rdata[BIT_EN]     = en_q & caps.msi;
    end
endmodule

// File: rtl/rdist_pend_track.sv
// Pending tracker: counts propagation requests not yet acknowledged,
// remembers whether an enable clear is among them, and holds a busy
// flag across the pending-table load.
// Assumes fewer than 2**CNT_W requests are ever outstanding at once and
// that acknowledges arrive only for issued requests (extra ones are dropped).
module rdist_pend_track #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic issue_en_clr,
    input  logic ack,
    input  logic load_go,
    input  logic load_done,
    output logic wpend,
    output logic clr_pend
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             clr_pend_q;
    logic             load_busy_q;
    logic             ack_ok;

    assign ack_ok = ack && (cnt_q != '0);

    // next outstanding count
    always_comb begin
        cnt_d = cnt_q;
        if (issue && !ack_ok)      cnt_d = cnt_q + CNT_W'(1);
        else if (!issue && ack_ok) cnt_d = cnt_q - CNT_W'(1);
    end

    // counter, clear-pending and load-busy state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            clr_pend_q  <= 1'b0;
            load_busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (issue && issue_en_clr)  clr_pend_q <= 1'b1;
            else if (cnt_d == '0)       clr_pend_q <= 1'b0;
            if (load_go)                load_busy_q <= 1'b1;
            else if (load_done)         load_busy_q <= 1'b0;
        end
    end

    assign wpend    = (cnt_q != '0) | load_busy_q;
    assign clr_pend = clr_pend_q;
endmodule

// File: rtl/rdist_elig.sv
// Eligibility and reselection: per-group one-of-N eligibility from sleep,
// exclude and group enables; registered reselect pulse when the exclude
// bit of a forwarded interrupt's group changes.
module rdist_elig
    import rdist_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pe_asleep,
    input  logic             wake_flag,
    input  logic [N_GRP-1:0] grp_en,
    input  logic [N_GRP-1:0] excl_q,
    input  logic [N_GRP-1:0] excl_chg,
    input  logic             fwd_valid,
    input  logic [1:0]       fwd_grp,
    output logic [N_GRP-1:0] elig,
    output logic             resel_req
);
    logic awake_ok;
    logic hit;
    logic resel_q;

    assign awake_ok = ~pe_asleep | wake_flag;

    // eligibility for each group
    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_elig
            assign elig[g] = awake_ok & grp_en[g] & ~excl_q[g];
        end
    endgenerate

    // does the change touch the forwarded group
    always_comb begin
        hit = 1'b0;
        for (int g = 0; g < N_GRP; g++) begin
            if (fwd_grp == 2'(g)) hit = excl_chg[g];
        end
    end

    // one-cycle reselect pulse
    always_ff @(posedge clk) begin
        if (!rst_n) resel_q <= 1'b0;
        else        resel_q <= fwd_valid & hit;
    end

    assign resel_req = resel_q;
endmodule

// File: rtl/rdist_ctl_reg.sv
// Redistributor control register top. Holds exclude bits and the
// message-interrupt enable, issues propagation and load requests, gates
// doorbell/translation traffic and reports eligibility.
// Assumes one-cycle write strobes and straps stable outside reset.
module rdist_ctl_reg
    import rdist_ctl_pkg::*;
#(
    parameter int PEND_CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_excl,
    input  logic             cap_one_sec,
    input  logic             cap_msi,
    input  logic             cap_inval,
    input  logic             cap_clearable,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    input  logic             bus_secure,
    output logic [31:0]      bus_rdata,
    input  logic             upstream_busy,
    output logic             prop_req,
    input  logic             prop_ack,
    output logic             load_start,
    input  logic             load_done,
    output logic             msi_en,
    input  logic             doorbell_in,
    output logic             doorbell_out,
    input  logic             xlate_in,
    output logic             xlate_accept,
    input  logic             pe_asleep,
    input  logic             wake_flag,
    input  logic [2:0]       grp_en,
    output logic [2:0]       elig,
    input  logic             fwd_valid,
    input  logic [1:0]       fwd_grp,
    output logic             resel_req,
    output logic             proto_err
);
    caps_t            caps;
    logic [N_GRP-1:0] wmask, excl_q, excl_d, excl_chg;
    logic             en_q, en_set, en_clr, err_set, issue;
    logic             wpend, clr_pend;
    logic             prop_q, load_q, err_q;
    logic             wr_en_bit;
    logic             unused_wbits;

    assign caps = '{excl: cap_excl, one_sec: cap_one_sec, msi: cap_msi,
                    inval: cap_inval, clrcap: cap_clearable};

    assign unused_wbits = ^{bus_wdata[31:27], bus_wdata[23:1]};
    assign wr_en_bit    = bus_wdata[BIT_EN];

    rdist_access_gate u_gate (
        .caps          (caps),
        .secure        (bus_secure),
        .excl_q        (excl_q),
        .en_q          (en_q),
        .wpend         (wpend),
        .upstream_busy (upstream_busy),
        .wmask         (wmask),
        .rdata         (bus_rdata)
    );

    // next exclude bits under the access mask
    always_comb begin
        for (int g = 0; g < N_GRP; g++) begin
            excl_d[g] = (bus_wr && wmask[g]) ? bus_wdata[BIT_EXCL0 + g] : excl_q[g];
        end
    end

    assign excl_chg = excl_d ^ excl_q;

    // enable transitions and illegal sequencing
    always_comb begin
        en_set  = bus_wr & caps.msi & wr_en_bit & ~en_q & ~clr_pend;
        en_clr  = bus_wr & caps.msi & ~wr_en_bit & en_q & caps.clrcap;
        err_set = bus_wr & caps.msi &
                  ((wr_en_bit & ~en_q & clr_pend) |
                   (~wr_en_bit & en_q & ~caps.clrcap));
        issue   = bus_wr & ((|excl_chg) | en_clr);
    end

    // stored fields and registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            excl_q <= '0;
            en_q   <= 1'b0;
            prop_q <= 1'b0;
            load_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            excl_q <= excl_d;
            if (en_set)      en_q <= 1'b1;
            else if (en_clr) en_q <= 1'b0;
            prop_q <= issue;
            load_q <= en_set;
            err_q  <= err_q | err_set;
        end
    end

    rdist_pend_track #(.CNT_W(PEND_CNT_W)) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (issue),
        .issue_en_clr (en_clr),
        .ack          (prop_ack),
        .load_go      (en_set),
        .load_done    (load_done),
        .wpend        (wpend),
        .clr_pend     (clr_pend)
    );

    rdist_elig u_elig (
        .clk       (clk),
        .rst_n     (rst_n),
        .pe_asleep (pe_asleep),
        .wake_flag (wake_flag),
        .grp_en    (grp_en),
        .excl_q    (excl_q),
        .excl_chg  (excl_chg),
        .fwd_valid (fwd_valid),
        .fwd_grp   (fwd_grp),
        .elig      (elig),
        .resel_req (resel_req)
    );

    assign prop_req     = prop_q;
    assign load_start   = load_q;
    assign proto_err    = err_q;
    assign msi_en       = en_q & caps.msi;
    assign doorbell_out = doorbell_in & msi_en;
    assign xlate_accept = xlate_in & msi_en;
endmodule

// File: rtl/rdist_ctl_chk.sv
// Checker for rdist_ctl_reg, bound to every instance of the top.
module rdist_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cap_msi,
    input logic [31:0] bus_rdata,
    input logic        upstream_busy,
    input logic        prop_req,
    input logic        load_start,
    input logic        msi_en,
    input logic        doorbell_out,
    input logic        xlate_accept,
    input logic        pe_asleep,
    input logic        wake_flag,
    input logic [2:0]  elig,
    input logic        proto_err
);
    AST_UPEND_MIRROR:   assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31] == upstream_busy);                                  // R2
    AST_REQ_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        prop_req |-> bus_rdata[3]);                                       // R5
    AST_LOAD_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |-> (bus_rdata[3] && msi_en));                         // R6
    AST_NO_EN_NO_CAP:   assert property (@(posedge clk) disable iff (!rst_n)
        !cap_msi |-> !msi_en);                                            // R7
    AST_DISCARD_OFF:    assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |-> (!doorbell_out && !xlate_accept));                    // R8
    AST_SLEEP_NO_ELIG:  assert property (@(posedge clk) disable iff (!rst_n)
        (pe_asleep && !wake_flag) |-> (elig == 3'b000));                  // R9
    AST_ERR_STICKY:     assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);                                         // R11
endmodule

bind rdist_ctl_reg rdist_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cap_msi       (cap_msi),
    .bus_rdata     (bus_rdata),
    .upstream_busy (upstream_busy),
    .prop_req      (prop_req),
    .load_start    (load_start),
    .msi_en        (msi_en),
    .doorbell_out  (doorbell_out),
    .xlate_accept  (xlate_accept),
    .pe_asleep     (pe_asleep),
    .wake_flag     (wake_flag),
    .elig          (elig),
    .proto_err     (proto_err)
);

// File: tb/tb_rdist_ctl_reg.sv
// Directed bench for rdist_ctl_reg: one task per scenario.
module tb_rdist_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_excl = 1'b1, cap_one_sec = 1'b0, cap_msi = 1'b1;
    logic        cap_inval = 1'b1, cap_clearable = 1'b1;
    logic        bus_wr = 1'b0, bus_secure = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        upstream_busy = 1'b0;
    logic        prop_req, prop_ack = 1'b0;
    logic        load_start, load_done = 1'b0;
    logic        msi_en;
    logic        doorbell_in = 1'b0, doorbell_out;
    logic        xlate_in = 1'b0, xlate_accept;
    logic        pe_asleep = 1'b0, wake_flag = 1'b0;
    logic [2:0]  grp_en = 3'b000, elig;
    logic        fwd_valid = 1'b0;
    logic [1:0]  fwd_grp = 2'd3;
    logic        resel_req, proto_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rdist_ctl_reg dut (
        .clk(clk), .rst_n(rst_n),
        .cap_excl(cap_excl), .cap_one_sec(cap_one_sec), .cap_msi(cap_msi),
        .cap_inval(cap_inval), .cap_clearable(cap_clearable),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_rdata(bus_rdata), .upstream_busy(upstream_busy),
        .prop_req(prop_req), .prop_ack(prop_ack),
        .load_start(load_start), .load_done(load_done), .msi_en(msi_en),
        .doorbell_in(doorbell_in), .doorbell_out(doorbell_out),
        .xlate_in(xlate_in), .xlate_accept(xlate_accept),
        .pe_asleep(pe_asleep), .wake_flag(wake_flag), .grp_en(grp_en),
        .elig(elig), .fwd_valid(fwd_valid), .fwd_grp(fwd_grp),
        .resel_req(resel_req), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic ex, input logic one, input logic msi, input logic clr);
        @(negedge clk);
        rst_n = 1'b0;
        cap_excl = ex; cap_one_sec = one; cap_msi = msi; cap_clearable = clr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // write lands on the next posedge; returns on the following negedge
    task automatic wr(input logic [31:0] d, input logic sec);
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = d; bus_secure = sec;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sec, output logic [31:0] d);
        bus_secure = sec;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack();
        @(negedge clk); prop_ack = 1'b1;
        @(negedge clk); prop_ack = 1'b0;
    endtask

    task automatic done();
        @(negedge clk); load_done = 1'b1;
        @(negedge clk); load_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(1'b1, d);
        chk("R1 R2 reset word", d, 32'h0000_0006);
        chk("R1 pulses", {29'd0, prop_req, load_start, resel_req}, 32'd0);
        chk("R1 enable/err", {30'd0, msi_en, proto_err}, 32'd0);
        upstream_busy = 1'b1;
        rd(1'b1, d);
        chk("R2 upstream bit", d, 32'h8000_0006);
        upstream_busy = 1'b0;
    endtask

    task automatic t_excl_pend();
        logic [31:0] d;
        wr(32'h0700_0000, 1'b1);
        chk("R5 req pulse", {31'd0, prop_req}, 32'd1);
        rd(1'b1, d); chk("R4 secure read", d, 32'h0700_000E);
        rd(1'b0, d); chk("R4 nonsecure read", d, 32'h0200_000E);
        step();
        chk("R5 pulse one cycle", {31'd0, prop_req}, 32'd0);
        wr(32'h0600_0000, 1'b1);
        ack();
        rd(1'b1, d); chk("R5 one ack of two", d, 32'h0600_000E);
        ack();
        rd(1'b1, d); chk("R5 all acked", d, 32'h0600_0006);
    endtask

    task automatic t_nonsecure();
        logic [31:0] d;
        wr(32'h0000_0000, 1'b0);
        rd(1'b1, d); chk("R4 ns clears only g1ns", d, 32'h0400_000E);
        ack();
        wr(32'h0700_0000, 1'b0);
        rd(1'b1, d); chk("R4 ns cannot set g0", d, 32'h0600_000E);
        ack();
        wr(32'h0000_0000, 1'b1);
        ack();
        wr(32'h0000_0000, 1'b1);
        chk("R5 no change no req", {31'd0, prop_req}, 32'd0);
        rd(1'b1, d); chk("R5 idle word", d, 32'h0000_0006);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(32'h0000_0001, 1'b1);
        chk("R6 load pulse", {30'd0, load_start, msi_en}, 32'd3);
        rd(1'b1, d); chk("R6 pending during load", d, 32'h0000_000F);
        step();
        chk("R6 pulse one cycle", {31'd0, load_start}, 32'd0);
        done();
        rd(1'b1, d); chk("R6 after done", d, 32'h0000_0007);
    endtask

    task automatic t_disable_seq();
        logic [31:0] d;
        doorbell_in = 1'b1; xlate_in = 1'b1;
        #1;
        chk("R8 pass when on", {30'd0, doorbell_out, xlate_accept}, 32'd3);
        wr(32'h0000_0000, 1'b1);
        chk("R5 clear req", {30'd0, prop_req, msi_en}, 32'd2);
        chk("R8 discard when off", {30'd0, doorbell_out, xlate_accept}, 32'd0);
        wr(32'h0000_0001, 1'b1);
        chk("R11 set during clear", {29'd0, proto_err, msi_en, load_start}, 32'd4);
        ack();
        rd(1'b1, d); chk("R11 ignored set", d, 32'h0000_0006);
        wr(32'h0000_0001, 1'b1);
        chk("R6 legal reset of enable", {30'd0, load_start, msi_en}, 32'd3);
        done();
        doorbell_in = 1'b0; xlate_in = 1'b0;
    endtask

    task automatic t_elig();
        grp_en = 3'b111;
        #1; chk("R9 all eligible", {29'd0, elig}, 32'd7);
        wr(32'h0200_0001, 1'b1);
        chk("R9 g1ns excluded", {29'd0, elig}, 32'd5);
        ack();
        pe_asleep = 1'b1; #1;
        chk("R9 asleep no wake", {29'd0, elig}, 32'd0);
        wake_flag = 1'b1; #1;
        chk("R9 asleep with wake", {29'd0, elig}, 32'd5);
        grp_en = 3'b110; pe_asleep = 1'b0; wake_flag = 1'b0; #1;
        chk("R9 group enable off", {29'd0, elig}, 32'd4);
        grp_en = 3'b111;
    endtask

    task automatic t_resel();
        fwd_valid = 1'b1; fwd_grp = 2'd1;
        wr(32'h0000_0001, 1'b1);
        chk("R10 own group change", {31'd0, resel_req}, 32'd1);
        step();
        chk("R10 pulse one cycle", {31'd0, resel_req}, 32'd0);
        ack();
        wr(32'h0100_0001, 1'b1);
        chk("R10 other group", {31'd0, resel_req}, 32'd0);
        ack();
        fwd_grp = 2'd0;
        wr(32'h0000_0001, 1'b1);
        chk("R10 group 0 change", {31'd0, resel_req}, 32'd1);
        ack();
        fwd_valid = 1'b0;
    endtask

    task automatic t_straps_off();
        logic [31:0] d;
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        wr(32'h0700_0001, 1'b1);
        rd(1'b1, d); chk("R3 R7 fields absent", d, 32'h0000_0004);
        chk("R7 no load no req", {29'd0, load_start, prop_req, msi_en}, 32'd0);
    endtask

    task automatic t_one_sec();
        logic [31:0] d;
        do_reset(1'b1, 1'b1, 1'b1, 1'b0);
        wr(32'h0700_0000, 1'b0);
        rd(1'b0, d); chk("R4 single state ns", d, 32'h0300_000C);
        ack();
        wr(32'h0300_0001, 1'b1);
        chk("R6 load", {31'd0, load_start}, 32'd1);
        done();
        wr(32'h0300_0000, 1'b1);
        chk("R12 enable sticks", {30'd0, msi_en, prop_req}, 32'd2);
        chk("R11 clear not allowed", {31'd0, proto_err}, 32'd1);
        rd(1'b1, d); chk("R12 word", d, 32'h0300_0005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_excl_pend();
        t_nonsecure();
        t_enable();
        t_disable_seq();
        t_elig();
        t_resel();
        t_straps_off();
        t_one_sec();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule